// File: doc/BRIEF.md
# Configuration Byte Access Port

This block gives a parallel programmer access to a small controller's configuration bytes. These are three fuse bytes, one lock byte, a short run of identification (signature) bytes and one oscillator calibration byte. The programmer first uses a load strobe to latch an 8-bit command. It may then latch an address byte and a data byte. It reads by pulling the read enable low while two byte-select inputs pick which byte appears. The fuse, signature and calibration values are fixed by parameters. The lock byte is a register that resets to a parameter value.

The lock byte can be changed in two ways. A lock-write command followed by a falling edge on the write strobe can only program bits to 0. An erase command followed by a write-strobe falling edge returns every lock bit to 1. Each accepted write holds the ready output low for a parameterised number of cycles. While ready is low, every load and write is ignored. The data bus is presented as a value plus a drive enable, and the chip-level pad turns that pair into a tri-state driver. A bit value of 0 means "programmed" in every byte.

Top module: `cfg_byte_port`

## Requirements
- R1: With command 0x04 latched and `rd_en_n` low, `{sel_hi,sel_lo}` picks the byte on `dq_out`: 00 gives the fuse low byte, 11 the fuse high byte, 10 the extended fuse byte and 01 the lock byte.
- R2: With command 0x08 latched and `rd_en_n` low, `sel_lo`=0 gives signature byte N for address N (0..SIG_COUNT-1), or 0xFF beyond that range. `sel_lo`=1 gives the calibration byte at address 0x00, or 0xFF at any other address.
- R3: Command 0x20, the latched data byte, and then a high-to-low transition of `wstb_n` replace the lock byte with old AND data. Lock bits 7:6 are never altered by a lock write.
- R4: No lock write turns a 0 lock bit back to 1. Command 0x80 followed by a `wstb_n` falling edge sets all eight lock bits to 1.
- R5: If lock bits 1:0 are both 0 before a lock write, that write leaves lock bits 5:2 unchanged.
- R6: After an accepted write edge, `ready` is low for exactly BUSY_CYC clock cycles, beginning at the clock edge that sampled the strobe.
- R7: While `ready` is low, the three load strobes and any `wstb_n` edge have no effect.
- R8: `dq_drive` is 1 only while `rd_en_n` is 0 and the latched command is 0x04 or 0x08. `dq_out` is 0x00 whenever `dq_drive` is 0.
- R9: After reset the command is 0x00 (no drive), the lock byte equals LOCK_INIT and `ready` is 1.
- R10: A `wstb_n` falling edge under any command other than 0x20 or 0x80 changes nothing. Holding `wstb_n` low does not start a second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_cmd | input | 1 | Latch `din` as the command |
| ld_addr | input | 1 | Latch `din` as the address low byte |
| ld_data | input | 1 | Latch `din` as the data low byte |
| din | input | 8 | Byte to be latched |
| wstb_n | input | 1 | Active-low write strobe; acts on its falling edge |
| rd_en_n | input | 1 | Active-low read enable |
| sel_lo | input | 1 | Byte select, low bit |
| sel_hi | input | 1 | Byte select, high bit |
| dq_out | output | 8 | Read data |
| dq_drive | output | 1 | Pad drive enable for `dq_out` |
| ready | output | 1 | 1 when idle, 0 during a write |

## Verification
The hardest state to reach from the ports is the boot-lock protection. It needs an earlier write that programs both low lock bits, a full busy window spent waiting, and only then a second write whose data tries to clear bits 5:2. The stimulus builds that history and then attacks the ignored paths. It issues a command load in the middle of a busy window and shows that the old command still controls the drive. It holds the strobe low past the end of the busy window. It finally erases and writes a fresh pattern. A behavioural model compares `ready`, `dq_drive` and `dq_out` on every clock.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam logic [7:0] CMD_NONE    = 8'h00;
   localparam logic [7:0] CMD_FUSE_RD = 8'h04;
   localparam logic [7:0] CMD_SIG_RD  = 8'h08;
   localparam logic [7:0] CMD_LOCK_WR = 8'h20;
   localparam logic [7:0] CMD_ERASE   = 8'h80;

   // {sel_hi, sel_lo} decode in fuse read mode
   typedef enum logic [1:0] {
      SEL_FUSE_LO  = 2'b00,
      SEL_LOCKBYTE = 2'b01,
      SEL_FUSE_EXT = 2'b10,
      SEL_FUSE_HI  = 2'b11
   } fsel_e;

   localparam logic [7:0] LOCK_KEEP_MASK = 8'hC0;
   localparam logic [7:0] BOOT_LOCK_MASK = 8'h3C;
endpackage

// File: rtl/cfg_cmd_latch.sv
module cfg_cmd_latch
   import cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy,
   input  logic       ld_cmd,
   input  logic       ld_addr,
   input  logic       ld_data,
   input  logic [7:0] din,
   input  logic       wstb_n,
   output logic [7:0] cmd_q,
   output logic [7:0] addr_q,
   output logic [7:0] data_q,
   output logic       lock_go,
   output logic       erase_go
);
   logic wstb_prev;
   logic wr_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= CMD_NONE;
         addr_q    <= 8'h00;
         data_q    <= 8'hFF;
         wstb_prev <= 1'b1;
      end else begin
         wstb_prev <= wstb_n;
         if (!busy) begin
            if (ld_cmd)  cmd_q  <= din;
            if (ld_addr) addr_q <= din;
            if (ld_data) data_q <= din;
         end
      end
   end

   assign wr_edge  = wstb_prev && !wstb_n && !busy;
   assign lock_go  = wr_edge && (cmd_q == CMD_LOCK_WR);
   assign erase_go = wr_edge && (cmd_q == CMD_ERASE);

   assert_busy_holds_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cmd_q) && $stable(addr_q) && $stable(data_q)));

   assert_single_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wstb_n && (lock_go || erase_go)) |=> !(lock_go || erase_go));
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
   import cfg_pkg::*;
#(
   parameter logic [7:0] LOCK_INIT = 8'hFF,
   parameter int unsigned BUSY_CYC = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock_go,
   input  logic       erase_go,
   input  logic [7:0] data_q,
   output logic [7:0] lock_q,
   output logic       busy
);
   localparam int unsigned CW = $clog2(BUSY_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

   logic [CW-1:0] cnt_q;
   logic          mode3;
   logic [7:0]    keep;

   generate
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("BUSY_CYC must be at least 1");
      end
   endgenerate

   assign mode3 = (lock_q[1:0] == 2'b00);
   assign keep  = LOCK_KEEP_MASK | (mode3 ? BOOT_LOCK_MASK : 8'h00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= LOCK_INIT;
         cnt_q  <= '0;
      end else begin
         if (erase_go)
            lock_q <= 8'hFF;
         else if (lock_go)
            lock_q <= lock_q & (data_q | keep);
         if (lock_go || erase_go)
            cnt_q <= LOAD;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

   assert_no_unprogram_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_go |=> ((lock_q & ~$past(lock_q)) == 8'h00));

   assert_boot_protect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[1:0] == 2'b00 && !erase_go) |=> $stable(lock_q[5:2]));

   assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_go || erase_go) |=> busy);

   assert_quiet_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock_go || erase_go) |=> $stable(lock_q));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
   import cfg_pkg::*;
#(
   parameter logic [7:0] FUSE_LO   = 8'h62,
   parameter logic [7:0] FUSE_HI   = 8'hDF,
   parameter logic [7:0] FUSE_EXT  = 8'hF9,
   parameter int unsigned SIG_COUNT = 3,
   parameter logic [SIG_COUNT*8-1:0] SIG_BYTES = 24'h0A921E,
   parameter logic [7:0] CAL_BYTE  = 8'h9C
) (
   input  logic [7:0] cmd_q,
   input  logic [7:0] addr_q,
   input  logic [7:0] lock_q,
   input  logic       rd_en_n,
   input  logic       sel_lo,
   input  logic       sel_hi,
   output logic [7:0] dq_out,
   output logic       dq_drive
);
   logic [SIG_COUNT-1:0] sig_hit;
   logic [7:0]           sig_byte;
   logic [7:0]           rd_byte;
   fsel_e                fsel;

   generate
      if (SIG_COUNT < 1 || SIG_COUNT > 256) begin : g_bad_sig
         $error("SIG_COUNT must lie in 1..256");
      end
      for (genvar g = 0; g < SIG_COUNT; g++) begin : g_sig
         assign sig_hit[g] = (addr_q == 8'(g));
      end
   endgenerate

   always_comb begin
      sig_byte = 8'hFF;
      for (int i = 0; i < SIG_COUNT; i++)
         if (sig_hit[i]) sig_byte = SIG_BYTES[i*8 +: 8];
   end

   assign fsel = fsel_e'({sel_hi, sel_lo});

   always_comb begin
      rd_byte = 8'h00;
      if (cmd_q == CMD_FUSE_RD) begin
         unique case (fsel)
            SEL_FUSE_LO:  rd_byte = FUSE_LO;
            SEL_LOCKBYTE: rd_byte = lock_q;
            SEL_FUSE_EXT: rd_byte = FUSE_EXT;
            SEL_FUSE_HI:  rd_byte = FUSE_HI;
         endcase
      end else if (cmd_q == CMD_SIG_RD) begin
         if (sel_lo) rd_byte = (addr_q == 8'h00) ? CAL_BYTE : 8'hFF;
         else        rd_byte = sig_byte;
      end
   end

   assign dq_drive = !rd_en_n && (cmd_q == CMD_FUSE_RD || cmd_q == CMD_SIG_RD);
   assign dq_out   = dq_drive ? rd_byte : 8'h00;
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
   import cfg_pkg::*;
#(
   parameter logic [7:0] FUSE_LO   = 8'h62,
   parameter logic [7:0] FUSE_HI   = 8'hDF,
   parameter logic [7:0] FUSE_EXT  = 8'hF9,
   parameter logic [7:0] LOCK_INIT = 8'hFF,
   parameter int unsigned SIG_COUNT = 3,
   parameter logic [SIG_COUNT*8-1:0] SIG_BYTES = 24'h0A921E,
   parameter logic [7:0] CAL_BYTE  = 8'h9C,
   parameter int unsigned BUSY_CYC = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_cmd,
   input  logic       ld_addr,
   input  logic       ld_data,
   input  logic [7:0] din,
   input  logic       wstb_n,
   input  logic       rd_en_n,
   input  logic       sel_lo,
   input  logic       sel_hi,
   output logic [7:0] dq_out,
   output logic       dq_drive,
   output logic       ready
);
   logic [7:0] cmd_q, addr_q, data_q, lock_q;
   logic       lock_go, erase_go, busy;

   cfg_cmd_latch u_latch (
      .clk, .rst_n, .busy, .ld_cmd, .ld_addr, .ld_data, .din, .wstb_n,
      .cmd_q, .addr_q, .data_q, .lock_go, .erase_go
   );

   cfg_lock_store #(.LOCK_INIT(LOCK_INIT), .BUSY_CYC(BUSY_CYC)) u_store (
      .clk, .rst_n, .lock_go, .erase_go, .data_q, .lock_q, .busy
   );

   cfg_read_mux #(
      .FUSE_LO(FUSE_LO), .FUSE_HI(FUSE_HI), .FUSE_EXT(FUSE_EXT),
      .SIG_COUNT(SIG_COUNT), .SIG_BYTES(SIG_BYTES), .CAL_BYTE(CAL_BYTE)
   ) u_mux (
      .cmd_q, .addr_q, .lock_q, .rd_en_n, .sel_lo, .sel_hi, .dq_out, .dq_drive
   );

   assign ready = !busy;

   assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(lock_go || erase_go));

   assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_FUSE_RD && cmd_q != CMD_SIG_RD) |-> (!dq_drive && dq_out == 8'h00));
endmodule

// File: tb/tb_cfg_byte_port.sv
`timescale 1ns/1ps
module tb_cfg_byte_port;
   localparam int BUSY = 5;
   localparam int WATCHDOG = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_cmd = 0, ld_addr = 0, ld_data = 0, wstb_n = 1, rd_en_n = 1;
   logic sel_lo = 0, sel_hi = 0;
   logic [7:0] din = 8'h00;
   logic [7:0] dq_out;
   logic dq_drive, ready;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cfg_byte_port #(.BUSY_CYC(BUSY)) dut (
      .clk, .rst_n, .ld_cmd, .ld_addr, .ld_data, .din, .wstb_n,
      .rd_en_n, .sel_lo, .sel_hi, .dq_out, .dq_drive, .ready
   );

   // reference model
   int m_cmd, m_addr, m_data, m_lock, m_cnt;
   bit m_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = 0; m_addr = 0; m_data = 255; m_lock = 255; m_cnt = 0; m_prev = 1;
      end else begin
         bit go;
         go = !wstb_n && m_prev && (m_cnt == 0);
         m_prev = wstb_n;
         if (m_cnt > 0) m_cnt = m_cnt - 1;
         else begin
            if (go && m_cmd == 8'h80) begin
               m_lock = 255; m_cnt = BUSY;
            end else if (go && m_cmd == 8'h20) begin
               bit prot;
               prot = ((m_lock & 3) == 0);
               for (int b = 0; b < 6; b++)
                  if (!(prot && b >= 2) && !m_data[b]) m_lock = m_lock & ~(1 << b);
               m_cnt = BUSY;
            end
            if (ld_cmd)  m_cmd  = din;
            if (ld_addr) m_addr = din;
            if (ld_data) m_data = din;
         end
      end
   end

   function automatic int exp_byte();
      int sigs[3] = '{8'h1E, 8'h92, 8'h0A};
      if (m_cmd == 8'h04) begin
         case ({sel_hi, sel_lo})
            2'b00: return 8'h62;
            2'b11: return 8'hDF;
            2'b10: return 8'hF9;
            default: return m_lock;
         endcase
      end
      if (sel_lo) return (m_addr == 0) ? 8'h9C : 8'hFF;
      return (m_addr < 3) ? sigs[m_addr] : 8'hFF;
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit drv;
         drv = !rd_en_n && (m_cmd == 8'h04 || m_cmd == 8'h08);
         chk("R6 ready", ready, (m_cnt == 0));
         chk("R8 drive", dq_drive, drv);
         if (drv) chk(m_cmd == 8'h04 ? "R1 data" : "R2 data", dq_out, exp_byte());
         else     chk("R8 idle data", dq_out, 0);
      end
   end

   task automatic step(); @(posedge clk); #2; endtask
   task automatic load_cmd(input logic [7:0] v); din = v; ld_cmd = 1; step(); ld_cmd = 0; endtask
   task automatic load_addr(input logic [7:0] v); din = v; ld_addr = 1; step(); ld_addr = 0; endtask
   task automatic load_data(input logic [7:0] v); din = v; ld_data = 1; step(); ld_data = 0; endtask
   task automatic pulse_wr(); wstb_n = 0; step(); wstb_n = 1; step(); endtask
   task automatic wait_ready(); for (int i = 0; i < 100 && !ready; i++) step(); endtask
   task automatic rd(input logic hi, input logic lo, input int exp, input string tag);
      sel_hi = hi; sel_lo = lo; rd_en_n = 0;
      @(negedge clk); #1;
      chk(tag, dq_out, exp);
      step(); rd_en_n = 1;
   endtask
   task automatic read_lock(input int exp, input string tag);
      load_cmd(8'h04); rd(1'b0, 1'b1, exp, tag);
   endtask

   initial begin
      #(WATCHDOG * 20);
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      // R9 reset state
      chk("R9 ready", ready, 1);
      rd_en_n = 0; @(negedge clk); #1; chk("R9 no drive", dq_drive, 0); step(); rd_en_n = 1;
      read_lock(8'hFF, "R9 lock init");
      // R1 fuse mapping
      load_cmd(8'h04);
      rd(0, 0, 8'h62, "R1 fuse low");
      rd(1, 1, 8'hDF, "R1 fuse high");
      rd(1, 0, 8'hF9, "R1 fuse ext");
      // R2 signature and calibration
      load_cmd(8'h08);
      load_addr(8'h00); rd(0, 0, 8'h1E, "R2 sig0"); rd(0, 1, 8'h9C, "R2 cal");
      load_addr(8'h01); rd(0, 0, 8'h92, "R2 sig1"); rd(0, 1, 8'hFF, "R2 cal addr1");
      load_addr(8'h02); rd(0, 0, 8'h0A, "R2 sig2");
      load_addr(8'h03); rd(0, 0, 8'hFF, "R2 sig out of range");
      // R8 release
      @(negedge clk); #1; chk("R8 rd_en_n high", dq_drive, 0);
      // R3 lock write, R6 busy, R7 ignore during busy
      load_cmd(8'h20); load_data(8'hFC);
      wstb_n = 0; step(); wstb_n = 1;
      @(negedge clk); #1; chk("R6 busy after edge", ready, 0);
      din = 8'h04; ld_cmd = 1; step(); ld_cmd = 0;
      wstb_n = 0; step(); wstb_n = 1;
      wait_ready();
      rd(0, 1, 8'h00, "R7 cmd load ignored no drive");
      chk("R7 drive stays off", dq_drive, 0);
      read_lock(8'hFC, "R3 lock after write");
      // R5 boot protection in mode 3, R4 no clear
      load_cmd(8'h20); load_data(8'h00); pulse_wr(); wait_ready();
      read_lock(8'hFC, "R5 boot bits kept");
      load_cmd(8'h20); load_data(8'hFF); pulse_wr(); wait_ready();
      read_lock(8'hFC, "R4 no unprogram");
      // R4 erase
      load_cmd(8'h80); pulse_wr(); wait_ready();
      read_lock(8'hFF, "R4 erase");
      // R3 boot bit write when not protected, bits 7:6 kept
      load_cmd(8'h20); load_data(8'hEF); pulse_wr(); wait_ready();
      read_lock(8'hEF, "R3 boot bit programmed");
      load_cmd(8'h20); load_data(8'h3F); pulse_wr(); wait_ready();
      read_lock(8'hEF, "R3 top bits kept");
      // R10 write under read command
      load_cmd(8'h04); wstb_n = 0; step(); wstb_n = 1;
      @(negedge clk); #1; chk("R10 no busy on read cmd", ready, 1);
      rd(0, 1, 8'hEF, "R10 lock unchanged");
      // R10 held strobe
      load_cmd(8'h20); load_data(8'hFB);
      wstb_n = 0;
      repeat (BUSY + 6) step();
      @(negedge clk); #1; chk("R10 held strobe no retrigger", ready, 1);
      wstb_n = 1; step();
      read_lock(8'hEB, "R10 single write");
      repeat (3) step();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule